// File: doc/BRIEF.md
# Watchdog Timer with Early-Warning NMI

This block is a host-refreshed watchdog. Software writes a 16-bit reload value into a register window; once the watchdog has been armed, a counter loaded from that value steps down by one on each coarse tick. A tick is an external enable pulse that stands for 128 ms. If software stops writing the reload register, the block first sends a one-cycle non-maskable interrupt pulse. This pulse comes 70 ticks, about 9 seconds, before the end. When the count runs out, the block raises a reset request that removes power from the system. The request stays high until the system reset input clears it.

Arming is one-way. Writing the code 0x0085 to the control register starts the watchdog, and no later write stops it. For a timeout of M minutes, software writes the reload value M*60000/128. The supported range is 2 to 30 minutes, which gives reload values from 937 to 14062. The tick width, the warning lead and the reset default are parameters.

Top module: `wdog_nmi_top`

## Requirements
- R1: After the synchronous active-low reset, the watchdog is unarmed, the interrupt and reset outputs are low, the reload register (offset 0x70) reads 937 (a 2-minute timeout) and the control register (offset 0x72) reads 0x0000.
- R2: A write of exactly 0x0085 to offset 0x72 arms the watchdog, and the control register then reads 0x0085. A write of any other value to 0x72 leaves it unarmed: the control register still reads 0x0000, and no amount of ticking raises the interrupt or the reset.
- R3: Once armed, the watchdog stays armed. A later write of 0x0000 to offset 0x72 leaves the control register reading 0x0085, and the countdown runs on to a reset.
- R4: A write to offset 0x70 stores the value, which reads back from 0x70, and reloads the countdown with it. While unarmed, ticks do not count.
- R5: The interrupt output is a pulse one clock long. It appears in the cycle after the tick that brings the count down to 70 or below, and it fires at most once per expiry.
- R6: The reset output rises in the cycle after the tick that brings the count to zero. This is exactly as many ticks after the last refresh as the value loaded, and 70 ticks after the interrupt when that value is above 70.
- R7: A reload written after the interrupt but before expiry cancels the pending reset, and the next expiry raises a fresh interrupt.
- R8: Once raised, the reset output stays high, whatever is written and however many ticks arrive, until the reset input is taken low. No interrupt fires while it is high.
- R9: When a reload write and a tick arrive in the same cycle, the written value wins and the tick is dropped.
- R10: When the loaded value is 70 or less, the interrupt fires on the first tick after the refresh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset; the only way to clear the reset request |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 8 | Register write offset |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 8 | Register read offset |
| rd_data | output | 16 | Read data for rd_addr, combinational |
| tick_en | input | 1 | Coarse time-base enable, one pulse per 128 ms |
| nmi_pulse | output | 1 | One-cycle early-warning interrupt |
| rst_req | output | 1 | Power-removal reset request, held until rst_n |

## Verification
The assertions assume that tick_en is the only thing that advances time. They also assume that writes arrive as single-cycle strobes with a stable address and data. The bench drives every input on the falling clock edge and holds it for one full cycle, so each write and each tick is seen at exactly one rising edge. The bench uses small reload values (20 to 100), so that whole expiries fit in a short run. It samples both outputs after every tick, which lets it pin down the exact tick at which the interrupt and the reset appear.

// File: rtl/wdog_pkg.sv
// Package: shared types and timing helpers for the watchdog.
// Assumes the time base is a whole number of milliseconds per tick.
package wdog_pkg;

    // Countdown phases: unarmed, counting, warning already issued, tripped
    typedef enum logic [1:0] {
        WD_IDLE = 2'd0,
        WD_RUN  = 2'd1,
        WD_WARN = 2'd2,
        WD_TRIP = 2'd3
    } wd_state_e;

    // Convert a timeout in minutes into a tick count
    function automatic int unsigned minutes_to_ticks(int unsigned minutes, int unsigned tick_ms);
        return (minutes * 60 * 1000) / tick_ms;
    endfunction

    // Convert a lead time in milliseconds into a tick count
    function automatic int unsigned ms_to_ticks(int unsigned ms, int unsigned tick_ms);
        return ms / tick_ms;
    endfunction

endpackage

// File: rtl/wdog_regs.sv
// Module: register window of the watchdog.
// Holds the reload value and the one-way arm flag, turns reload writes
// into a load strobe for the counter, and returns read data.
// Assumes writes are single-cycle strobes.
module wdog_regs #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 16,
    parameter logic [ADDR_W-1:0] RELOAD_OFS = 8'h70,
    parameter logic [ADDR_W-1:0] CTRL_OFS   = 8'h72,
    parameter logic [DATA_W-1:0] ARM_CODE   = 16'h0085,
    parameter logic [DATA_W-1:0] RESET_VAL  = 16'd937
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              armed_o,
    output logic              load_o,
    output logic [DATA_W-1:0] load_val_o
);

    logic [DATA_W-1:0] reload_q;
    logic              armed_q;
    logic              hit_reload;
    logic              hit_ctrl;

    // Decode which register a write targets
    always_comb begin
        hit_reload = wr_en && (wr_addr == RELOAD_OFS);
        hit_ctrl   = wr_en && (wr_addr == CTRL_OFS);
    end

    // Store the reload value on every write to its offset
    always_ff @(posedge clk) begin
        if (!rst_n)
            reload_q <= RESET_VAL;
        else if (hit_reload)
            reload_q <= wr_data;
    end

    // Arm on the exact code; once set, only system reset clears it
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else if (hit_ctrl && (wr_data == ARM_CODE))
            armed_q <= 1'b1;
    end

    // Send a reload write straight on to the counter as a load strobe
    always_comb begin
        load_o     = hit_reload;
        load_val_o = wr_data;
    end

    // Read mux: the control register reads back the arm code once armed
    always_comb begin
        if (rd_addr == RELOAD_OFS)
            rd_data = reload_q;
        else if (rd_addr == CTRL_OFS)
            rd_data = armed_q ? ARM_CODE : '0;
        else
            rd_data = '0;
    end

    assign armed_o = armed_q;

endmodule

// File: rtl/wdog_countdown.sv
// Module: tick-driven down counter with early warning and trip.
// Counts one per tick once armed. It pulses the warning once when the count
// first lands at or below LEAD, and trips when the count reaches zero.
// A load takes priority over a tick in the same cycle. Once tripped, the
// counter is frozen until reset.
module wdog_countdown
    import wdog_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int LEAD  = 70,
    parameter logic [CNT_W-1:0] RESET_VAL = 16'd937
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             armed,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             nmi_o,
    output logic             trip_o
);

    localparam logic [CNT_W-1:0] LEAD_V = CNT_W'(LEAD);

    wd_state_e        st_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_dec;
    logic             nmi_q;
    logic             counting;

    // Next count on a tick, saturating at zero
    always_comb begin
        cnt_dec  = (cnt_q == '0) ? '0 : cnt_q - CNT_W'(1);
        counting = (st_q == WD_RUN) || (st_q == WD_WARN);
    end

    // Phase, count and warning pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= WD_IDLE;
            cnt_q <= RESET_VAL;
            nmi_q <= 1'b0;
        end else begin
            nmi_q <= 1'b0;
            if (st_q != WD_TRIP) begin
                if (load) begin
                    cnt_q <= load_val;
                    if (st_q == WD_WARN)
                        st_q <= WD_RUN;
                end else if (st_q == WD_IDLE) begin
                    if (armed)
                        st_q <= WD_RUN;
                end else if (counting && tick) begin
                    cnt_q <= cnt_dec;
                    if ((st_q == WD_RUN) && (cnt_dec <= LEAD_V))
                        nmi_q <= 1'b1;
                    if (cnt_dec == '0)
                        st_q <= WD_TRIP;
                    else if (cnt_dec <= LEAD_V)
                        st_q <= WD_WARN;
                end
            end
        end
    end

    assign nmi_o  = nmi_q;
    assign trip_o = (st_q == WD_TRIP);

endmodule

// File: rtl/wdog_nmi_top.sv
// Module: watchdog top. It joins the register window to the countdown.
// Assumes tick_en is a single-cycle pulse from a 128 ms time base, and
// rst_n is the system reset that follows a power removal.
module wdog_nmi_top
    import wdog_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 16,
    parameter int TICK_MS     = 128,
    parameter int LEAD_MS     = 9000,
    parameter int DEFAULT_MIN = 2,
    parameter logic [ADDR_W-1:0] RELOAD_OFS = 8'h70,
    parameter logic [ADDR_W-1:0] CTRL_OFS   = 8'h72,
    parameter logic [DATA_W-1:0] ARM_CODE   = 16'h0085
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              tick_en,
    output logic              nmi_pulse,
    output logic              rst_req
);

    localparam int NMI_LEAD = int'(ms_to_ticks(LEAD_MS, TICK_MS));
    localparam logic [DATA_W-1:0] RESET_RELOAD =
        DATA_W'(minutes_to_ticks(DEFAULT_MIN, TICK_MS));

    logic              armed;
    logic              load;
    logic [DATA_W-1:0] load_val;

    // Register window
    wdog_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .RELOAD_OFS(RELOAD_OFS), .CTRL_OFS(CTRL_OFS),
        .ARM_CODE(ARM_CODE), .RESET_VAL(RESET_RELOAD)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .armed_o(armed), .load_o(load), .load_val_o(load_val)
    );

    // Countdown with warning and trip
    wdog_countdown #(
        .CNT_W(DATA_W), .LEAD(NMI_LEAD), .RESET_VAL(RESET_RELOAD)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .armed(armed), .load(load), .load_val(load_val),
        .tick(tick_en),
        .nmi_o(nmi_pulse), .trip_o(rst_req)
    );

endmodule

// File: rtl/wdog_nmi_chk.sv
// Checker: timing properties of the watchdog outputs and the arm flag.
module wdog_nmi_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h72,
    parameter logic [DATA_W-1:0] ARM_CODE = 16'h0085
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              tick_en,
    input logic              armed,
    input logic              nmi_pulse,
    input logic              rst_req
);

    assert_quiet_unarmed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (!nmi_pulse && !rst_req));

    assert_arm_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == CTRL_OFS && wr_data == ARM_CODE) |=> armed);

    assert_arm_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> armed);

    assert_nmi_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_pulse |=> !nmi_pulse);

    assert_nmi_after_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_pulse |-> $past(tick_en));

    assert_trip_after_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> $past(tick_en));

    assert_trip_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req);

    assert_no_nmi_tripped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req && $past(rst_req)) |-> !nmi_pulse);

endmodule

bind wdog_nmi_top wdog_nmi_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_OFS(CTRL_OFS), .ARM_CODE(ARM_CODE)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tick_en(tick_en), .armed(armed),
    .nmi_pulse(nmi_pulse), .rst_req(rst_req)
);

// File: tb/wdog_nmi_top_bench.sv
// Directed bench for the watchdog: one task per scenario.
module wdog_nmi_top_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0]  A_RELOAD = 8'h70;
    localparam logic [7:0]  A_CTRL   = 8'h72;
    localparam logic [15:0] ARM      = 16'h0085;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        tick_en = 1'b0;
    logic        nmi_pulse;
    logic        rst_req;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Results of the last run_ticks call
    int nmi_cnt, nmi_first, rst_first;
    bit rst_fell;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_nmi_top u_wdog_nmi_top (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .tick_en(tick_en), .nmi_pulse(nmi_pulse), .rst_req(rst_req)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0; tick_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic arm();
        bus_write(A_CTRL, ARM);
        @(negedge clk);
    endtask

    task automatic run_ticks(input int n);
        nmi_cnt = 0; nmi_first = 0; rst_first = 0; rst_fell = 0;
        for (int i = 1; i <= n; i++) begin
            tick_en = 1'b1;
            @(negedge clk);
            if (nmi_pulse) begin
                nmi_cnt++;
                if (nmi_first == 0) nmi_first = i;
            end
            if (rst_req && rst_first == 0) rst_first = i;
            if (!rst_req && rst_first != 0) rst_fell = 1;
        end
        tick_en = 1'b0;
    endtask

    task automatic t_reset_state();
        int v;
        do_reset();
        bus_read(A_RELOAD, v); check("R1 reload default", v, 937);
        bus_read(A_CTRL, v);   check("R1 control default", v, 0);
        check("R1 nmi low", int'(nmi_pulse), 0);
        check("R1 reset low", int'(rst_req), 0);
    endtask

    task automatic t_wrong_code();
        int v;
        do_reset();
        bus_write(A_RELOAD, 16'd100);
        bus_read(A_RELOAD, v); check("R4 reload readback", v, 100);
        bus_write(A_CTRL, 16'h0084);
        @(negedge clk);
        bus_read(A_CTRL, v); check("R2 wrong code not armed", v, 0);
        run_ticks(120);
        check("R2 R4 unarmed no nmi", nmi_cnt, 0);
        check("R2 R4 unarmed no reset", int'(rst_req), 0);
    endtask

    task automatic t_expiry();
        int v;
        do_reset();
        bus_write(A_RELOAD, 16'd100);
        arm();
        bus_read(A_CTRL, v); check("R2 control armed", v, 16'h0085);
        run_ticks(100);
        check("R5 nmi tick", nmi_first, 30);
        check("R5 nmi count", nmi_cnt, 1);
        check("R6 reset tick", rst_first, 100);
    endtask

    task automatic t_sticky();
        int v;
        do_reset();
        bus_write(A_RELOAD, 16'd100);
        arm();
        bus_write(A_CTRL, 16'h0000);
        bus_read(A_CTRL, v); check("R3 still armed", v, 16'h0085);
        run_ticks(100);
        check("R3 reset after disarm try", rst_first, 100);
    endtask

    task automatic t_cancel();
        do_reset();
        bus_write(A_RELOAD, 16'd100);
        arm();
        run_ticks(40);
        check("R7 first nmi", nmi_first, 30);
        check("R7 no reset yet", rst_first, 0);
        bus_write(A_RELOAD, 16'd100);
        run_ticks(100);
        check("R7 second nmi tick", nmi_first, 30);
        check("R7 second nmi count", nmi_cnt, 1);
        check("R7 reset after refresh", rst_first, 100);
    endtask

    task automatic t_hold_and_short();
        do_reset();
        bus_write(A_RELOAD, 16'd20);
        arm();
        run_ticks(20);
        check("R10 nmi on first tick", nmi_first, 1);
        check("R10 single nmi", nmi_cnt, 1);
        check("R6 short reset tick", rst_first, 20);
        bus_write(A_RELOAD, 16'd100);
        bus_write(A_CTRL, ARM);
        run_ticks(50);
        check("R8 reset held", int'(rst_fell), 0);
        check("R8 reset still high", int'(rst_req), 1);
        check("R8 no nmi while tripped", nmi_cnt, 0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R8 cleared by system reset", int'(rst_req), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_same_cycle();
        do_reset();
        bus_write(A_RELOAD, 16'd100);
        arm();
        run_ticks(10);
        wr_en = 1'b1; wr_addr = A_RELOAD; wr_data = 16'd50; tick_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick_en = 1'b0;
        run_ticks(50);
        check("R9 load beats tick", rst_first, 50);
        check("R9 R10 nmi after short load", nmi_first, 1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        t_reset_state();
        t_wrong_code();
        t_expiry();
        t_sticky();
        t_cancel();
        t_hold_and_short();
        t_same_cycle();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule